// File: doc/BRIEF.md
# Audio serial clock generator

This block produces the bit clock and the left/right frame clock for a stereo audio serial port. When the port owns the clocks, both are divided down from the module clock. When another device owns them, the clocks arriving from outside are passed straight to the outputs. In both cases the block also produces two strobes for the data serializer. A bit strobe lasts one module-clock cycle and marks each falling bit-clock edge, which is when data shifts. A frame strobe marks the first bit of every frame.

The block is set up through one 32-bit control word written on a simple write port. The word selects clock ownership, the polarity of each clock, a bit-clock divide code, a logarithmic frame-length code and the framing format. Changes to the divide and frame-length codes are held back until the current frame ends, so a frame is never cut short. A per-instance parameter flips the meaning of the frame-clock polarity bit. This lets the block sit beside serial ports that define that polarity the other way round.

Top module: `aud_clkgen`

## Requirements
- R1: Control bits 12:9 hold the bit-clock divide code. Codes 0 through 13 divide the module clock by 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192. The bit strobe repeats at exactly that many module-clock cycles.
- R2: The reserved divide codes 14 and 15 behave as a divide by 192.
- R3: For every ratio other than 1, the bit clock is high for half the ratio and low for half. At ratio 1 the bit clock is the module clock, gated on while the block is clock owner.
- R4: Control bits 8:6 hold the frame code n. A frame is 16 shifted left by n bit clocks. Codes 5 to 7 give 256.
- R5: Control bits 3:2 hold the format. In format 0 (I2S), the frame clock is low for the first half of the frame and high for the second half, and each change comes one bit before that half starts.
- R6: In formats 1 (left-justified) and 2 (right-justified), the frame clock is low for bits 0 to half-1 and high for the rest, changing on the first bit of each half.
- R7: In format 3 (DSP), the frame clock is high only during bit 0 of each frame.
- R8: Control bit 14 inverts the bit clock. Control bit 13, XORed with the instance parameter LRCK_SENSE_INV, inverts the frame clock.
- R9: A new divide or frame code written while the clocks run takes effect at the next frame start. The frame in progress keeps the old codes.
- R10: With control bit 15 set, bclk_o and lrck_o equal ext_bclk_i and ext_lrck_i. The block then gives one bit strobe per falling edge of the external bit clock (after the bit-14 polarity) and one frame strobe on the first such edge that finds the normalized frame clock high after it was low.
- R11: After reset, the control word has bit 15 set and all other fields zero, so the outputs follow the external clocks and no strobe is raised.
- R12: In owner mode, the bit strobe is high for one module-clock cycle, in the cycle the normalized bit clock falls. The frame strobe rises only together with the bit strobe of bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the control word |
| cfg_wdata_i | input | 32 | Control word value |
| ext_bclk_i | input | 1 | Bit clock from another owner |
| ext_lrck_i | input | 1 | Frame clock from another owner |
| bclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock |
| bit_tick_o | output | 1 | One-cycle strobe at each falling bit-clock edge |
| frame_start_o | output | 1 | One-cycle strobe on bit 0 of a frame |

## Verification
The bench steps through every divide ratio class, including ratio 1, the largest ratio and the reserved codes, and every format. It checks period, duty, frame length and the frame-clock level on each bit. A wrong ratio table or a missing clamp shows up as a wrong strobe spacing. An off-by-one in the I2S lead puts the frame clock one bit late. A divide code rewritten mid-frame must leave the old strobe spacing in place until the frame strobe: a design that applies it at once would shorten that frame. A second instance with the polarity sense parameter flipped must give the opposite frame clock. In the external-clock mode, the strobe counts must match the number of edges driven, so a design that misses or duplicates edges through its synchronizer is caught.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;

  parameter int unsigned IDX_W = 8;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       slave;
    logic       bclk_inv;
    logic       lrck_inv;
    logic [3:0] bdiv;
    logic [2:0] fdiv;
    fmt_e       fmt;
  } ctl_t;

  // 1, 2, then alternating 3*2^k and 2^k; codes past 13 clamp to 192
  function automatic logic [7:0] bclk_ratio(input logic [3:0] code);
    logic [3:0] sh;
    logic [7:0] r;
    if (code >= 4'd13)     r = 8'd192;
    else if (code == 4'd0) r = 8'd1;
    else if (code == 4'd1) r = 8'd2;
    else if (code[0]) begin
      sh = (code - 4'd1) >> 1;
      r  = 8'd3 << sh;
    end else begin
      sh = (code >> 1) + 4'd1;
      r  = 8'd1 << sh;
    end
    return r;
  endfunction

  function automatic logic [2:0] frame_code_clamp(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  function automatic logic [IDX_W-1:0] frame_last(input logic [2:0] code);
    logic [IDX_W:0] f;
    f = (IDX_W+1)'(16) << frame_code_clamp(code);
    return IDX_W'(f - (IDX_W+1)'(1));
  endfunction

  function automatic logic [IDX_W-1:0] frame_half(input logic [2:0] code);
    return IDX_W'(8) << frame_code_clamp(code);
  endfunction

endpackage

// File: rtl/aud_clkgen_bdiv.sv
module aud_clkgen_bdiv #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             bclk_o,
  output logic             fall_pre_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             bclk_q;
  logic             flip;

  assign flip       = (cnt_q == half_i - CNT_W'(1));
  // falls at the coming edge; lets downstream registers switch with bclk
  assign fall_pre_o = run_i & (bypass_i | (flip & bclk_q));
  assign bclk_o     = bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!run_i || bypass_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (flip) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/aud_clkgen_frame.sv
module aud_clkgen_frame
  import aud_clkgen_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [2:0] fdiv_i,
  input  fmt_e       fmt_i,
  output logic       lrck_o,
  output logic       tick_o,
  output logic       frame_start_o,
  output logic       frame_end_o
);

  logic [IDX_W-1:0] idx_q, nxt, nxt2, last, half;
  logic             fresh_q, lrck_q, tick_q, fs_q, wrap, lrck_d;

  assign last        = frame_last(fdiv_i);
  assign half        = frame_half(fdiv_i);
  assign wrap        = fresh_q | (idx_q == last);
  assign nxt         = wrap ? '0 : idx_q + IDX_W'(1);
  assign nxt2        = (nxt == last) ? '0 : nxt + IDX_W'(1);
  assign frame_end_o = tick_i & wrap;

  always_comb begin
    unique case (fmt_i)
      FMT_I2S: lrck_d = (nxt2 >= half);
      FMT_DSP: lrck_d = (nxt == '0);
      default: lrck_d = (nxt >= half);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      fresh_q <= 1'b1;
      lrck_q  <= 1'b0;
      tick_q  <= 1'b0;
      fs_q    <= 1'b0;
    end else if (!run_i) begin
      idx_q   <= '0;
      fresh_q <= 1'b1;
      lrck_q  <= 1'b0;
      tick_q  <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      tick_q <= tick_i;
      fs_q   <= tick_i & (nxt == '0);
      if (tick_i) begin
        idx_q   <= nxt;
        fresh_q <= 1'b0;
        lrck_q  <= lrck_d;
      end
    end
  end

  assign lrck_o        = lrck_q;
  assign tick_o        = tick_q;
  assign frame_start_o = fs_q;

endmodule

// File: rtl/aud_clkgen_slv.sv
module aud_clkgen_slv #(
  parameter int unsigned SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrck_i,
  input  logic bclk_inv_i,
  input  logic lrck_pol_i,
  output logic tick_o,
  output logic frame_start_o
);

  logic [SYNC_W-1:0] b_sync_q, l_sync_q;
  logic              prev_b_q, l_at_tick_q, tick_q, fs_q;
  logic              nb, nl, fall;

  assign nb   = b_sync_q[SYNC_W-1] ^ bclk_inv_i;
  assign nl   = l_sync_q[SYNC_W-1] ^ lrck_pol_i;
  assign fall = prev_b_q & ~nb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_sync_q    <= '0;
      l_sync_q    <= '0;
      prev_b_q    <= 1'b0;
      l_at_tick_q <= 1'b0;
      tick_q      <= 1'b0;
      fs_q        <= 1'b0;
    end else begin
      b_sync_q <= {b_sync_q[SYNC_W-2:0], bclk_i};
      l_sync_q <= {l_sync_q[SYNC_W-2:0], lrck_i};
      prev_b_q <= nb;
      tick_q   <= fall;
      fs_q     <= fall & nl & ~l_at_tick_q;
      if (fall) l_at_tick_q <= nl;
    end
  end

  assign tick_o        = tick_q;
  assign frame_start_o = fs_q;

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
#(
  parameter bit          LRCK_SENSE_INV = 1'b0,
  parameter int unsigned CNT_W          = 8,
  parameter int unsigned SYNC_W         = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        ext_bclk_i,
  input  logic        ext_lrck_i,
  output logic        bclk_o,
  output logic        lrck_o,
  output logic        bit_tick_o,
  output logic        frame_start_o
);

  ctl_t       ctl_q, wr_ctl;
  logic [3:0] act_bdiv_q;
  logic [2:0] act_fdiv_q;
  logic [7:0] ratio;
  logic       run, bypass, bclk_inv, lrck_pol;
  logic       div_bclk, fall_pre;
  logic       m_lrck, m_tick, m_fs, frame_end;
  logic       s_tick, s_fs;
  logic       unused_cfg_bits;
  fmt_e       fmt;

  assign wr_ctl = '{
    slave:    cfg_wdata_i[15],
    bclk_inv: cfg_wdata_i[14],
    lrck_inv: cfg_wdata_i[13],
    bdiv:     cfg_wdata_i[12:9],
    fdiv:     cfg_wdata_i[8:6],
    fmt:      fmt_e'(cfg_wdata_i[3:2])
  };
  // word size and spare bits belong to the serializer
  assign unused_cfg_bits = ^{cfg_wdata_i[31:16], cfg_wdata_i[5:4], cfg_wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= '0;
      ctl_q.slave <= 1'b1;
    end else if (cfg_we_i) begin
      ctl_q <= wr_ctl;
    end
  end

  assign run      = ~ctl_q.slave;
  assign bclk_inv = ctl_q.bclk_inv;
  assign lrck_pol = ctl_q.lrck_inv ^ LRCK_SENSE_INV;
  assign fmt      = ctl_q.fmt;

  // divider codes: track freely while stopped, latch at frame end while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_bdiv_q <= '0;
      act_fdiv_q <= '0;
    end else if (!run) begin
      act_bdiv_q <= cfg_we_i ? wr_ctl.bdiv : ctl_q.bdiv;
      act_fdiv_q <= cfg_we_i ? wr_ctl.fdiv : ctl_q.fdiv;
    end else if (frame_end) begin
      act_bdiv_q <= ctl_q.bdiv;
      act_fdiv_q <= ctl_q.fdiv;
    end
  end

  assign ratio  = bclk_ratio(act_bdiv_q);
  assign bypass = (ratio == 8'd1);

  aud_clkgen_bdiv #(.CNT_W(CNT_W)) u_bdiv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .bypass_i  (bypass),
    .half_i    (CNT_W'(ratio >> 1)),
    .bclk_o    (div_bclk),
    .fall_pre_o(fall_pre)
  );

  aud_clkgen_frame u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .tick_i       (fall_pre),
    .fdiv_i       (act_fdiv_q),
    .fmt_i        (fmt),
    .lrck_o       (m_lrck),
    .tick_o       (m_tick),
    .frame_start_o(m_fs),
    .frame_end_o  (frame_end)
  );

  aud_clkgen_slv #(.SYNC_W(SYNC_W)) u_slv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bclk_i       (ext_bclk_i),
    .lrck_i       (ext_lrck_i),
    .bclk_inv_i   (bclk_inv),
    .lrck_pol_i   (lrck_pol),
    .tick_o       (s_tick),
    .frame_start_o(s_fs)
  );

  assign bclk_o        = run ? ((bypass ? clk_i : div_bclk) ^ bclk_inv) : ext_bclk_i;
  assign lrck_o        = run ? (m_lrck ^ lrck_pol) : ext_lrck_i;
  assign bit_tick_o    = run ? m_tick : s_tick;
  assign frame_start_o = run ? m_fs : s_fs;

endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       bypass_i,
  input logic       bclk_inv_i,
  input logic       lrck_pol_i,
  input logic [1:0] fmt_i,
  input logic [3:0] act_bdiv_i,
  input logic [2:0] act_fdiv_i,
  input logic       frame_end_i,
  input logic       bclk_o,
  input logic       lrck_o,
  input logic       bit_tick_o,
  input logic       frame_start_o
);

  a_r12_start_with_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> bit_tick_o);

  a_r3_tick_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !bypass_i && !$past(bypass_i) && $stable(bclk_inv_i) && bit_tick_o)
    |-> $fell(bclk_o ^ bclk_inv_i));

  a_r12_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bypass_i && bit_tick_o) |=> (!bit_tick_o || bypass_i || !run_i));

  a_r7_dsp_pulse_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && fmt_i == 2'd3 && $stable(fmt_i) && $stable(lrck_pol_i)
     && $rose(lrck_o ^ lrck_pol_i)) |-> frame_start_o);

  a_r9_codes_hold_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(frame_end_i))
    |-> ($stable(act_bdiv_i) && $stable(act_fdiv_i)));

endmodule

bind aud_clkgen aud_clkgen_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .run_i        (run),
  .bypass_i     (bypass),
  .bclk_inv_i   (bclk_inv),
  .lrck_pol_i   (lrck_pol),
  .fmt_i        (fmt),
  .act_bdiv_i   (act_bdiv_q),
  .act_fdiv_i   (act_fdiv_q),
  .frame_end_i  (frame_end),
  .bclk_o       (bclk_o),
  .lrck_o       (lrck_o),
  .bit_tick_o   (bit_tick_o),
  .frame_start_o(frame_start_o)
);

// File: tb/aud_clkgen_tb_top.sv
`timescale 1ns/1ps
module aud_clkgen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        ext_b = 1'b0, ext_l = 1'b0;
  logic        bclk, lrck, tick, fs;
  logic        bclk2, lrck2, tick2, fs2;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  aud_clkgen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .ext_bclk_i(ext_b), .ext_lrck_i(ext_l),
    .bclk_o(bclk), .lrck_o(lrck), .bit_tick_o(tick), .frame_start_o(fs));

  aud_clkgen #(.LRCK_SENSE_INV(1'b1)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .ext_bclk_i(ext_b), .ext_lrck_i(ext_l),
    .bclk_o(bclk2), .lrck_o(lrck2), .bit_tick_o(tick2), .frame_start_o(fs2));

  // {bdiv, fdiv, fmt, bclk_inv, lrck_inv}
  localparam logic [10:0] VECS [8] = '{
    {4'd1,  3'd0, 2'd0, 1'b0, 1'b0},
    {4'd3,  3'd1, 2'd1, 1'b1, 1'b0},
    {4'd0,  3'd0, 2'd3, 1'b0, 1'b0},
    {4'd13, 3'd0, 2'd2, 1'b0, 1'b1},
    {4'd14, 3'd0, 2'd0, 1'b0, 1'b0},
    {4'd5,  3'd4, 2'd3, 1'b0, 1'b1},
    {4'd2,  3'd7, 2'd1, 1'b0, 1'b0},
    {4'd9,  3'd2, 2'd0, 1'b1, 1'b1}
  };

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 1;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 12;  6: return 16;  7: return 24;
      8: return 32;  9: return 48;  10: return 64; 11: return 96;
      12: return 128;
      default: return 192;
    endcase
  endfunction

  function automatic int exp_frame(input int code);
    return 16 << ((code > 4) ? 4 : code);
  endfunction

  function automatic logic exp_lrck(input int idx, input int fmt, input int flen, input logic li);
    int h;
    logic v;
    h = flen / 2;
    case (fmt)
      0: v = (((idx + 1) % flen) >= h);
      3: v = (idx == 0);
      default: v = (idx >= h);
    endcase
    return v ^ li;
  endfunction

  function automatic logic [31:0] mk(input logic sl, input logic bi, input logic li,
                                     input logic [3:0] bd, input logic [2:0] fd, input logic [1:0] fm);
    return {16'h0, sl, bi, li, bd, fd, 2'b01, fm, 2'b00};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_fs(input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (fs) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input logic [10:0] v);
    int bd, fd, fm, ratio, flen, since, hi, idx, frames;
    int e_per, e_duty, e_len, e_lr, e_sense, bad_per, bad_len;
    logic bi, li;
    bit ok;
    bd = int'(v[10:7]); fd = int'(v[6:4]); fm = int'(v[3:2]);
    bi = v[1]; li = v[0];
    ratio = exp_ratio(bd); flen = exp_frame(fd);
    e_per = 0; e_duty = 0; e_len = 0; e_lr = 0; e_sense = 0;
    bad_per = ratio; bad_len = flen;
    wr(mk(1'b1, 1'b0, 1'b0, 4'd0, 3'd0, 2'd0));
    wr(mk(1'b0, bi, li, v[10:7], v[6:4], v[3:2]));
    wait_fs(4 * ratio * flen + 16, ok);
    check(ok, "R12 first frame start", int'(ok), 1);
    idx = 0; since = 0; hi = 0; frames = 0;
    if (lrck !== exp_lrck(0, fm, flen, li)) e_lr++;
    while (ok && frames < 2) begin
      @(negedge clk);
      since++;
      if ((bclk ^ bi) === 1'b1) hi++;
      if (tick) begin
        if (since != ratio) begin e_per++; bad_per = since; end
        if (ratio > 1 ? (hi != ratio / 2) : (hi != 0)) e_duty++;
        since = 0; hi = 0;
        if (fs) begin
          if (idx != flen - 1) begin e_len++; bad_len = idx + 1; end
          idx = 0; frames++;
        end else begin
          idx++;
        end
        if (lrck !== exp_lrck(idx, fm, flen, li)) e_lr++;
        if (lrck2 !== ~lrck) e_sense++;
      end
    end
    check(e_per == 0, "R1 R2 bit period", bad_per, ratio);
    check(e_duty == 0, "R3 bit clock duty", e_duty, 0);
    check(e_len == 0, "R4 frame length", bad_len, flen);
    check(e_lr == 0, "R5 R6 R7 R8 frame clock level", e_lr, 0);
    check(e_sense == 0, "R8 polarity sense parameter", e_sense, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int since, errs, s_ticks, s_fs;
    bit ok, seen;
    ext_b = 1'b1; ext_l = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state: external clocks pass, no strobes
    check(bclk === 1'b1, "R11 reset bclk follows ext", int'(bclk), 1);
    check(lrck === 1'b0, "R11 reset lrck follows ext", int'(lrck), 0);
    check(tick === 1'b0 && fs === 1'b0, "R11 reset strobes low", int'(tick | fs), 0);
    ext_b = 1'b0; ext_l = 1'b1;
    #1;
    check(bclk === 1'b0 && lrck === 1'b1, "R10 passthrough", int'({bclk, lrck}), 1);
    ext_l = 1'b0;

    foreach (VECS[i]) run_vec(VECS[i]);

    // R9: divide code rewritten mid-frame waits for the frame end
    wr(mk(1'b1, 1'b0, 1'b0, 4'd0, 3'd0, 2'd0));
    wr(mk(1'b0, 1'b0, 1'b0, 4'd1, 3'd0, 2'd0));
    wait_fs(200, ok);
    repeat (3) begin
      do @(negedge clk); while (!tick);
    end
    wr(mk(1'b0, 1'b0, 1'b0, 4'd2, 3'd0, 2'd0));
    do @(negedge clk); while (!tick);
    since = 0; errs = 0; seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      since++;
      if (tick) begin
        if (!seen) begin
          if (since != 2) errs++;
          if (fs) seen = 1'b1;
          since = 0;
        end else begin
          check(since == 4, "R9 new ratio after frame start", since, 4);
          break;
        end
      end
    end
    check(errs == 0 && seen, "R9 old ratio kept to frame end", errs, 0);

    // R10: external clock mode strobes
    wr(mk(1'b1, 1'b0, 1'b0, 4'd0, 3'd0, 2'd0));
    s_ticks = 0; s_fs = 0;
    fork
      begin
        for (int b = 0; b < 64; b++) begin
          ext_l = ((b % 16) == 0);
          ext_b = 1'b1; repeat (4) @(negedge clk);
          ext_b = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
      end
      begin
        for (int c = 0; c < 64 * 8 + 8; c++) begin
          @(negedge clk);
          if (tick) s_ticks++;
          if (fs) s_fs++;
        end
      end
    join
    check(s_ticks == 64, "R10 ext bit strobes", s_ticks, 64);
    check(s_fs == 4, "R10 ext frame strobes", s_fs, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule